// File: doc/BRIEF.md
# One-Hot Addressed Register File

This block is a small storage array of `WORDS` entries, each `WIDTH` bits wide, with one write port and one read port. Neither port carries a binary address: each takes a select vector with one bit per word. Address decoding is therefore left to the surrounding datapath, and the array holds no decoder of its own.

Write data is taken from one of two input buses. A single bus-select bit chooses which one. Every word whose write-select bit is set is loaded with that data on the rising clock edge.

The read port is combinational. It returns the bitwise OR of the words whose read-select bits are set, so a one-hot select yields exactly that word. When the `ZERO_WORD` parameter is non-zero, entry 0 is a constant-zero register: it accepts writes but never changes, and it always reads as zero. Stored contents have no reset.

Top module: `onehot_regfile`

## Requirements
- R1: On a rising clock edge, when `wr_bus_sel` is 0, every word whose `wr_sel` bit is 1 takes the value on `wr_bus0`.
- R2: On a rising clock edge, when `wr_bus_sel` is 1, every word whose `wr_sel` bit is 1 takes the value on `wr_bus1`.
- R3: A word whose `wr_sel` bit is 0 keeps its value across the clock edge.
- R4: `rd_data` follows `rd_sel` and the stored contents combinationally, with no clock edge between a select change and the output change.
- R5: When `rd_sel` is all zeros, `rd_data` is all zeros.
- R6: When several `rd_sel` bits are set, `rd_data` is the bitwise OR of the selected words.
- R7: When several `wr_sel` bits are set, every selected word is written with the same data in that cycle.
- R8: A word that is written and read in the same cycle shows its old value on `rd_data` until the clock edge; there is no write-through bypass.
- R9: With `ZERO_WORD` non-zero, a read of word 0 (`rd_sel` bit 0) returns all zeros.
- R10: With `ZERO_WORD` non-zero, a write to word 0 is accepted and leaves word 0 reading as zero afterwards.
- R11: With `ZERO_WORD` equal to 0, word 0 stores and returns written data like any other word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| wr_bus_sel | input | 1 | Write source: 0 picks `wr_bus0`, 1 picks `wr_bus1` |
| rd_sel | input | WORDS | Read select, one bit per word (bit k selects word k) |
| wr_sel | input | WORDS | Write select, one bit per word (bit k selects word k) |
| wr_bus0 | input | WIDTH | First write data bus |
| wr_bus1 | input | WIDTH | Second write data bus |
| rd_data | output | WIDTH | Read data, the OR of the selected words |

## Verification
On every cycle, the assertions check several properties. They check that an idle read select gives zero and that word 0 reads as zero when it is hardwired. They check that a single-word write shows up on the next cycle, from the bus that `wr_bus_sel` chose, whenever the same word is still being read. They also check that the output holds steady across a cycle with no write and an unchanged read select.

Some behaviours can only be shown by the bench's scenarios against its own model of the array. These are the OR of several selected words, the fan-out of one write to several words, and the absence of write-through in the write cycle itself. The bench also contrasts a hardwired word 0 with an ordinary one, using two instances.

// File: rtl/onehot_rf_pkg.sv
package onehot_rf_pkg;
    typedef enum logic {
        WSRC_BUS0 = 1'b0,
        WSRC_BUS1 = 1'b1
    } wsrc_e;
endpackage

// File: rtl/rf_wsrc_mux.sv
module rf_wsrc_mux #(
    parameter int WIDTH = 32
) (
    input  logic             src_sel,
    input  logic [WIDTH-1:0] bus0,
    input  logic [WIDTH-1:0] bus1,
    output logic [WIDTH-1:0] wdata
);
    import onehot_rf_pkg::*;

    wsrc_e src;

    always_comb begin
        src = wsrc_e'(src_sel);
        case (src)
            WSRC_BUS1: wdata = bus1;
            default:   wdata = bus0;
        endcase
    end
endmodule

// File: rtl/rf_word_cell.sv
module rf_word_cell #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (we) begin
            cell_d.data = wdata;
        end
    end

    always_ff @(posedge clk) begin
        cell_q <= cell_d;
    end

    assign q = cell_q.data;
endmodule

// File: rtl/rf_read_or.sv
module rf_read_or #(
    parameter int WORDS = 8,
    parameter int WIDTH = 32
) (
    input  logic [WORDS-1:0]            sel,
    input  logic [WORDS-1:0][WIDTH-1:0] words,
    output logic [WIDTH-1:0]            dout
);
    always_comb begin
        dout = '0;
        for (int k = 0; k < WORDS; k++) begin
            dout = dout | (words[k] & {WIDTH{sel[k]}});
        end
    end
endmodule

// File: rtl/onehot_regfile.sv
module onehot_regfile #(
    parameter int WORDS     = 8,
    parameter int WIDTH     = 32,
    parameter int ZERO_WORD = 1
) (
    input  logic             clk,
    input  logic             wr_bus_sel,
    input  logic [WORDS-1:0] rd_sel,
    input  logic [WORDS-1:0] wr_sel,
    input  logic [WIDTH-1:0] wr_bus0,
    input  logic [WIDTH-1:0] wr_bus1,
    output logic [WIDTH-1:0] rd_data
);
    localparam int FIRST_STORED = (ZERO_WORD != 0) ? 1 : 0;

    logic [WIDTH-1:0]            wdata;
    logic [WORDS-1:0][WIDTH-1:0] words;

    rf_wsrc_mux #(.WIDTH(WIDTH)) u_wsrc (
        .src_sel (wr_bus_sel),
        .bus0    (wr_bus0),
        .bus1    (wr_bus1),
        .wdata   (wdata)
    );

    generate
        if (ZERO_WORD != 0) begin : g_hard_zero
            assign words[0] = '0;
        end
        for (genvar k = FIRST_STORED; k < WORDS; k++) begin : g_word
            rf_word_cell #(.WIDTH(WIDTH)) u_cell (
                .clk   (clk),
                .we    (wr_sel[k]),
                .wdata (wdata),
                .q     (words[k])
            );
        end
    endgenerate

    rf_read_or #(.WORDS(WORDS), .WIDTH(WIDTH)) u_read (
        .sel   (rd_sel),
        .words (words),
        .dout  (rd_data)
    );
endmodule

// File: rtl/onehot_regfile_chk.sv
module onehot_regfile_chk #(
    parameter int WORDS     = 8,
    parameter int WIDTH     = 32,
    parameter int ZERO_WORD = 1
) (
    input logic             clk,
    input logic             wr_bus_sel,
    input logic [WORDS-1:0] rd_sel,
    input logic [WORDS-1:0] wr_sel,
    input logic [WIDTH-1:0] wr_bus0,
    input logic [WIDTH-1:0] wr_bus1,
    input logic [WIDTH-1:0] rd_data
);
    localparam logic [WORDS-1:0] WORD0 = WORDS'(1);
    localparam logic             HARD0 = (ZERO_WORD != 0);

    logic primed_q = 1'b0;
    always_ff @(posedge clk) primed_q <= 1'b1;

    logic tracked_wr;
    assign tracked_wr = $onehot(wr_sel) && (rd_sel == wr_sel) && !(HARD0 && wr_sel[0]);

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!primed_q)
        (rd_sel == '0) |-> (rd_data == '0)); // R5

    AST_HARD_ZERO_READ: assert property (@(posedge clk) disable iff (!primed_q)
        (HARD0 && rd_sel == WORD0) |-> (rd_data == '0)); // R9

    AST_HARD_ZERO_WRITE: assert property (@(posedge clk) disable iff (!primed_q)
        (HARD0 && wr_sel[0]) |=> (rd_sel != WORD0 || rd_data == '0)); // R10

    AST_BUS0_WRITE_LANDS: assert property (@(posedge clk) disable iff (!primed_q)
        (tracked_wr && !wr_bus_sel) |=> (rd_sel != $past(rd_sel) || rd_data == $past(wr_bus0))); // R1

    AST_BUS1_WRITE_LANDS: assert property (@(posedge clk) disable iff (!primed_q)
        (tracked_wr && wr_bus_sel) |=> (rd_sel != $past(rd_sel) || rd_data == $past(wr_bus1))); // R2

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!primed_q)
        (wr_sel == '0) |=> (rd_sel != $past(rd_sel) || $stable(rd_data))); // R3
endmodule

bind onehot_regfile onehot_regfile_chk #(
    .WORDS(WORDS), .WIDTH(WIDTH), .ZERO_WORD(ZERO_WORD)
) u_chk (
    .clk(clk), .wr_bus_sel(wr_bus_sel), .rd_sel(rd_sel), .wr_sel(wr_sel),
    .wr_bus0(wr_bus0), .wr_bus1(wr_bus1), .rd_data(rd_data)
);

// File: tb/onehot_regfile_bench.sv
`timescale 1ns/1ps
module onehot_regfile_bench;
    localparam int WORDS = 8;
    localparam int WIDTH = 32;

    logic             clk = 1'b0;
    logic             wr_bus_sel = 1'b0;
    logic [WORDS-1:0] rd_sel = '0;
    logic [WORDS-1:0] wr_sel = '0;
    logic [WIDTH-1:0] wr_bus0 = '0;
    logic [WIDTH-1:0] wr_bus1 = '0;
    logic [WIDTH-1:0] rd_zero;
    logic [WIDTH-1:0] rd_plain;

    always #10 clk = ~clk; // 50 MHz

    onehot_regfile #(.WORDS(WORDS), .WIDTH(WIDTH), .ZERO_WORD(1)) u_onehot_regfile (
        .clk(clk), .wr_bus_sel(wr_bus_sel), .rd_sel(rd_sel), .wr_sel(wr_sel),
        .wr_bus0(wr_bus0), .wr_bus1(wr_bus1), .rd_data(rd_zero)
    );

    onehot_regfile #(.WORDS(WORDS), .WIDTH(WIDTH), .ZERO_WORD(0)) u_onehot_regfile_plain (
        .clk(clk), .wr_bus_sel(wr_bus_sel), .rd_sel(rd_sel), .wr_sel(wr_sel),
        .wr_bus0(wr_bus0), .wr_bus1(wr_bus1), .rd_data(rd_plain)
    );

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [WIDTH-1:0] model [WORDS];
    logic [WIDTH-1:0] q_zero [$];
    logic [WIDTH-1:0] q_plain [$];
    string            q_tag [$];

    // Driver: applies one cycle of stimulus, pushes the expected read, updates the model.
    task automatic drive(input logic [WORDS-1:0] ws, input logic bs,
                         input logic [WIDTH-1:0] d0, input logic [WIDTH-1:0] d1,
                         input logic [WORDS-1:0] rs, input string tag);
        logic [WIDTH-1:0] ez, ep, wd;
        @(posedge clk);
        #1;
        wr_sel = ws; wr_bus_sel = bs; wr_bus0 = d0; wr_bus1 = d1; rd_sel = rs;
        ez = '0; ep = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (rs[k]) begin
                ep = ep | model[k];
                if (k != 0) ez = ez | model[k];
            end
        end
        q_zero.push_back(ez);
        q_plain.push_back(ep);
        q_tag.push_back(tag);
        wd = bs ? d1 : d0;
        for (int k = 0; k < WORDS; k++) begin
            if (ws[k]) model[k] = wd;
        end
    endtask

    // Monitor: compares each expectation in the cycle it was driven, before the next edge.
    always @(negedge clk) begin
        if (q_tag.size() > 0) begin
            logic [WIDTH-1:0] ez, ep;
            string t;
            ez = q_zero.pop_front();
            ep = q_plain.pop_front();
            t  = q_tag.pop_front();
            total++;
            if (rd_zero !== ez) begin
                fails++;
                $display("FAIL %s (zero-word instance): got %h expected %h", t, rd_zero, ez);
            end
            total++;
            if (rd_plain !== ep) begin
                fails++;
                $display("FAIL %s (plain instance): got %h expected %h", t, rd_plain, ep);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < WORDS; k++) model[k] = 'x;

        // R5: idle read select gives zero, even before any word is written.
        drive('0, 1'b0, '0, '0, '0, "R5 idle read");

        // Fill every word; even words from bus 0 (R1), odd words from bus 1 (R2).
        for (int k = 0; k < WORDS; k++) begin
            drive(WORDS'(1) << k, k[0], 32'hA000_0000 + k, 32'hB000_0000 + k, '0,
                  "R5 idle read during fill");
        end

        // R4: combinational reads of each word; R9/R11 on word 0.
        for (int k = 0; k < WORDS; k++) begin
            string t;
            if (k == 0)           t = "R4 R9 R11 read word0";
            else if (k % 2 == 0)  t = "R4 R1 read bus0 word";
            else                  t = "R4 R2 read bus1 word";
            drive('0, 1'b0, '0, '0, WORDS'(1) << k, t);
        end

        // R8: write and read word 3 together; old value visible until the edge.
        drive(8'b0000_1000, 1'b0, 32'hDEAD_BEEF, 32'h1234_5678, 8'b0000_1000, "R8 no write-through");
        drive('0, 1'b1, 32'h0, 32'h0, 8'b0000_1000, "R1 new value after edge");
        drive('0, 1'b0, '0, '0, 8'b0000_0100, "R3 neighbour word2 kept");
        drive('0, 1'b0, '0, '0, 8'b0001_0000, "R3 neighbour word4 kept");

        // R7: one write fans out to words 5 and 7 from bus 1.
        drive(8'b1010_0000, 1'b1, 32'h0F0F_0F0F, 32'h5555_AAAA, '0, "R5 idle read");
        drive('0, 1'b0, '0, '0, 8'b0010_0000, "R7 multi-write word5");
        drive('0, 1'b0, '0, '0, 8'b1000_0000, "R7 multi-write word7");
        drive('0, 1'b0, '0, '0, 8'b0100_0000, "R3 word6 untouched by multi-write");

        // R6: OR of several selected words.
        drive('0, 1'b0, '0, '0, 8'b0000_0110, "R6 OR of words 1 and 2");
        drive('0, 1'b0, '0, '0, 8'b1010_1001, "R6 OR including word0");

        // R10/R11: write all ones to word 0, then read it.
        drive(8'b0000_0001, 1'b1, 32'h0, 32'hFFFF_FFFF, 8'b0000_0001, "R9 read word0 during write");
        drive('0, 1'b0, '0, '0, 8'b0000_0001, "R10 R11 word0 after write");
        drive(8'b0000_0011, 1'b0, 32'h7777_0001, 32'h0, '0, "R5 idle read");
        drive('0, 1'b0, '0, '0, 8'b0000_0011, "R10 R11 R7 words 0 and 1 after shared write");
        drive('0, 1'b0, '0, '0, '0, "R5 idle read at end");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule